// File: doc/BRIEF.md
# Relative Clock Frequency Meter

This block measures how fast a foreign clock runs compared with the local reference clock. It opens a counting gate of a fixed number of reference cycles. It counts the measured clock's rising edges while that gate is open. It then hands the count back to the reference domain, where it is held as an unsigned 16.16 fixed-point ratio. In this format an output of `0x0001_0000` means both clocks run at the same rate. An output of `0x0002_8000` means the measured clock is 2.5 times faster.

Measurements repeat without a break. The result register is reloaded once for every completed gate and holds its value in between. A processor can therefore read it at any time. It gets either the previous ratio or the new one, and never a value that is half updated.

The gate is carried into the measured domain as a single level through a two-flop synchronizer. The count returns as a frozen snapshot together with a toggled request flag. Only the flag is synchronized. The snapshot is sampled after the flag has settled, and the snapshot stays frozen until the next gate has run to completion.

Top module: `relclk_meter`

## Requirements
- R1: After reset, `ratio_o` is 0 and stays 0 until the first counting gate has completed and its count has been transferred; no update can appear within the first 2^WIN_LOG2 reference cycles after reset release.
- R2: The counting gate is open for exactly 2^WIN_LOG2 consecutive reference cycles, and a new gate opens as soon as the previous count has been taken over, so measurement is continuous.
- R3: `ratio_o` equals the number of measured-clock rising edges seen inside one gate, multiplied by 2^(16-WIN_LOG2). The bits [31:16] hold the integer part and the bits [15:0] hold the fraction of f_meas/f_ref. The accuracy is within ±3 counts.
- R4: The edge counter is CNT_W bits wide and saturates at 2^CNT_W-1 instead of wrapping. A saturated gate reports (2^CNT_W-1)·2^(16-WIN_LOG2).
- R5: `ratio_o` changes at most once per completed gate and holds its value between updates.
- R6: The multi-bit count crosses domains only as a snapshot register that changes solely when the gate closes. That change comes with a toggle of a single-bit request flag, and only the flag is synchronized into the reference domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference (processor) clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset; also resets the measured domain through a local synchronizer |
| meas_clk | input | 1 | Clock whose frequency is measured |
| ratio_o | output | 32 | Measured-to-reference frequency ratio, unsigned 16.16 |

## Verification
A new ratio appears one gate length plus the synchronizer latency of both domains after the measured clock has settled. With both clocks at similar rates this latency is under 20 reference cycles. After every change of the measured period, the bench therefore waits 700 reference cycles before it samples. That wait is more than two full gate-plus-handshake periods at WIN_LOG2 = 8, so the sampled value comes from a gate that ran entirely at the new rate. The reset window is sampled just before cycle 2^WIN_LOG2 and again 40 cycles after it. All samples are taken on the falling reference edge. Ratios are compared against a value computed from the two clock periods with a ±3-count tolerance, because the synchronizers can move the gate edges by one or two measured-clock cycles.

// File: rtl/rcfm_pkg.sv
package rcfm_pkg;
    localparam int FRAC_W = 16;
    localparam int RES_W  = 32;

    typedef enum logic {
        PH_GATE = 1'b0,
        PH_WAIT = 1'b1
    } rcfm_phase_e;
endpackage

// File: rtl/rcfm_sync.sv
module rcfm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rcfm_meas_cnt.sv
module rcfm_meas_cnt #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             meas_clk,
    input  logic             ref_rst_n,
    input  logic             gate_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             req_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Local reset: asserts asynchronously, releases on the measured clock
    logic [1:0] rst_sr_q;
    logic       meas_rst_n;

    always_ff @(posedge meas_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) rst_sr_q <= 2'b00;
        else            rst_sr_q <= {rst_sr_q[0], 1'b1};
    end
    assign meas_rst_n = rst_sr_q[1];

    logic gate_s;

    rcfm_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk   (meas_clk),
        .rst_n (meas_rst_n),
        .d_i   (gate_i),
        .q_o   (gate_s)
    );

    typedef struct packed {
        logic             gate_prev;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             req;
    } meas_st_t;

    meas_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.gate_prev = gate_s;
        if (gate_s && !st_q.gate_prev) begin
            st_d.cnt = CNT_W'(1);
        end else if (gate_s && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        if (!gate_s && st_q.gate_prev) begin
            st_d.hold = st_q.cnt;
            st_d.req  = ~st_q.req;
        end
    end

    always_ff @(posedge meas_clk or negedge meas_rst_n) begin
        if (!meas_rst_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign req_o  = st_q.req;

    // R3
    cnt_monotonic_chk: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        (gate_s && st_q.gate_prev) |=> (st_q.cnt >= $past(st_q.cnt)));

    // R4
    cnt_saturate_chk: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        (gate_s && st_q.gate_prev && st_q.cnt == CNT_MAX) |=> (st_q.cnt == CNT_MAX));

    // R6
    hold_frozen_chk: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        !$stable(st_q.hold) |-> $past(st_q.gate_prev && !gate_s));

    // R6
    req_with_close_chk: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
        !$stable(st_q.req) |-> $past(st_q.gate_prev && !gate_s));
endmodule

// File: rtl/rcfm_ref_ctl.sv
module rcfm_ref_ctl
    import rcfm_pkg::*;
#(
    parameter int WIN_LOG2    = 16,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             ref_rst_n,
    input  logic [CNT_W-1:0] hold_i,
    input  logic             req_i,
    output logic             gate_o,
    output logic [RES_W-1:0] ratio_o
);
    localparam int                  SHIFT   = FRAC_W - WIN_LOG2;
    localparam logic [WIN_LOG2-1:0] WIN_END = {WIN_LOG2{1'b1}};
    localparam int                  WIN_LEN = 1 << WIN_LOG2;

    logic req_s;

    rcfm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d_i   (req_i),
        .q_o   (req_s)
    );

    typedef struct packed {
        rcfm_phase_e         phase;
        logic [WIN_LOG2-1:0] win;
        logic                req_seen;
        logic [RES_W-1:0]    result;
    } ref_st_t;

    ref_st_t st_d, st_q;
    logic    req_edge;

    assign req_edge = (req_s != st_q.req_seen);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_GATE: begin
                st_d.win = st_q.win + WIN_LOG2'(1);
                if (st_q.win == WIN_END) begin
                    st_d.phase = PH_WAIT;
                    st_d.win   = '0;
                end
            end
            PH_WAIT: begin
                if (req_edge) begin
                    st_d.req_seen = req_s;
                    st_d.result   = RES_W'(hold_i) << SHIFT;
                    st_d.phase    = PH_GATE;
                end
            end
            default: st_d.phase = PH_GATE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign gate_o  = (st_q.phase == PH_GATE);
    assign ratio_o = st_q.result;

    // Checker-only run length of the open gate
    logic [WIN_LOG2:0] gate_run_q;
    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n)  gate_run_q <= '0;
        else if (gate_o) gate_run_q <= gate_run_q + (WIN_LOG2+1)'(1);
        else             gate_run_q <= '0;
    end

    // R2
    gate_length_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $fell(gate_o) |-> (gate_run_q == (WIN_LOG2+1)'(WIN_LEN)));

    // R5
    result_update_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !$stable(ratio_o) |-> $past(!gate_o && (req_s != st_q.req_seen)));

    // R2
    gate_reopen_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        $rose(gate_o) |-> $past(req_edge));
endmodule

// File: rtl/relclk_meter.sv
module relclk_meter #(
    parameter int WIN_LOG2    = 16,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        ref_clk,
    input  logic        ref_rst_n,
    input  logic        meas_clk,
    output logic [31:0] ratio_o
);
    logic             gate;
    logic [CNT_W-1:0] hold;
    logic             req;

    initial begin
        assert (WIN_LOG2 >= 1 && WIN_LOG2 <= rcfm_pkg::FRAC_W);
        assert (CNT_W >= 2 && CNT_W <= rcfm_pkg::FRAC_W + WIN_LOG2);
        assert (SYNC_STAGES >= 2);
    end

    rcfm_ref_ctl #(
        .WIN_LOG2    (WIN_LOG2),
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ref (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .hold_i    (hold),
        .req_i     (req),
        .gate_o    (gate),
        .ratio_o   (ratio_o)
    );

    rcfm_meas_cnt #(
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_meas (
        .meas_clk  (meas_clk),
        .ref_rst_n (ref_rst_n),
        .gate_i    (gate),
        .hold_o    (hold),
        .req_o     (req)
    );
endmodule

// File: tb/relclk_meter_test.sv
`timescale 1ns/1ps
module relclk_meter_test;
    localparam real REF_PERIOD = 5.0;
    localparam int  W_A = 8;
    localparam int  C_A = 24;
    localparam int  W_B = 4;
    localparam int  C_B = 6;

    logic        ref_clk = 1'b0;
    logic        meas_clk = 1'b0;
    logic        fast_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ratio_a, ratio_b;
    real         meas_half = 2.5;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5  ref_clk  = ~ref_clk;
    always #0.25 fast_clk = ~fast_clk;
    initial forever begin
        #(meas_half);
        meas_clk = ~meas_clk;
    end

    relclk_meter #(.WIN_LOG2(W_A), .CNT_W(C_A)) uut (
        .ref_clk(ref_clk), .ref_rst_n(rst_n), .meas_clk(meas_clk), .ratio_o(ratio_a));

    relclk_meter #(.WIN_LOG2(W_B), .CNT_W(C_B)) uut_sat (
        .ref_clk(ref_clk), .ref_rst_n(rst_n), .meas_clk(fast_clk), .ratio_o(ratio_b));

    function automatic real exp_ratio(input real period);
        return 65536.0 * REF_PERIOD / period;
    endfunction

    task automatic wait_ref(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    task automatic check_exact(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input logic [31:0] act, input real exp, input int win_log2);
        real tol, diff;
        tol  = 3.0 * (2.0 ** (16 - win_log2));
        diff = real'(act) - exp;
        if (diff < 0.0) diff = -diff;
        n_cmp++;
        if (diff > tol) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected about 0x%08h", req, act, int'(exp));
        end
    endtask

    task automatic run_period(input string req, input real period);
        meas_half = period / 2.0;
        wait_ref(700);
        check_near(req, ratio_a, exp_ratio(period), W_A);
    endtask

    initial begin
        void'($urandom(32'd4711));
        wait_ref(4);
        rst_n = 1'b1;
        wait_ref(10);
        // R1: reset value
        check_exact("R1 reset", ratio_a, 32'h0);
        wait_ref((1 << W_A) - 12);
        // R1: nothing before the first gate has closed
        check_exact("R1 before first gate", ratio_a, 32'h0);
        wait_ref(40);
        // R5: first result present shortly after the first gate closes
        check_near("R5 first update", ratio_a, exp_ratio(5.0), W_A);

        // R3: directed ratios below, at and above one
        run_period("R3 half rate", 10.0);
        run_period("R3 2.5x rate", 2.0);
        run_period("R3 4x rate", 1.25);
        run_period("R3 slow 1/8", 40.0);

        // R5: at most one update per gate (258+ cycles) over 600 cycles
        begin
            int          changes = 0;
            logic [31:0] prev = ratio_a;
            for (int i = 0; i < 600; i++) begin
                @(negedge ref_clk);
                if (ratio_a !== prev) changes++;
                prev = ratio_a;
            end
            n_cmp++;
            if (changes > 3) begin
                n_bad++;
                $display("FAIL R5 update rate: actual %0d changes expected <= 3", changes);
            end
        end

        // R2/R3: random periods, continuous measurement
        for (int k = 0; k < 6; k++) begin
            real p;
            p = 2.0 + real'($urandom % 381) / 10.0;
            run_period("R3 random", p);
        end

        // R4: saturating counter in the narrow instance (160 edges > 63)
        check_exact("R4 saturation", ratio_b, 32'(63) << (16 - W_B));
        wait_ref(300);
        check_exact("R4 saturation repeat", ratio_b, 32'(63) << (16 - W_B));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(REF_PERIOD * 150000.0);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule